// File: doc/BRIEF.md
# Timer-Chained SPI Master

This block is a single-lane SPI master built from two compare timers and two shift registers. It drives four pins: serial clock, serial data out, serial data in and an active-low select. The clock timer divides the module clock to make SCK and counts the edges of one 8-bit frame. The select timer is started when the transmit shifter takes a byte from the transmit buffer. It asserts select, lets one half SCK period pass, starts the clock timer, waits one more half period after the last edge, and then raises a one-cycle end-of-frame pulse.

Software writes a byte into the transmit buffer, and that write starts the frame. The received byte is delivered MSB first in a receive buffer, with a ready flag that a read clears. Both clock phases are supported, with SCK idling low. With the late phase (CPHA=1) and hold requested, select stays low between frames, so a multi-byte exchange looks like one burst to the slave.

The serial input passes through a two-stage synchronizer before it is sampled. The divider must therefore be even and at least 8, which keeps each SCK half period at four module clocks or more.

Top module: `spi_tmr_master`

## Requirements
- R1: While reset is asserted: cs_n is 1, sck is 0, mosi is 0, tx_empty is 1, rx_ready is 0 and xfer_done is 0.
- R2: sck idles at 0. During a frame it toggles every sck_div/2 module clocks and makes exactly 8 rising edges. sck_div must be even and at least 8.
- R3: With cpha=0, mosi carries bit 7 before the first rising sck edge and changes only on falling edges. The slave's bit is sampled on each rising edge.
- R4: With cpha=1, mosi first presents bit 7 on the first rising sck edge and changes only on rising edges. The slave's bit is sampled on each falling edge.
- R5: cs_n goes low in the cycle after the buffered byte moves into the shifter. It stays low until the frame's end pulse, and sck only toggles while cs_n is low.
- R6: With cpha=1 and cs_hold=1, cs_n stays low across back-to-back frames and rises about a cycle after cs_hold drops. With cpha=0, cs_hold has no effect and cs_n rises after each frame.
- R7: A tx_wr pulse makes tx_empty 0 in the next cycle. tx_empty returns to 1 when the byte moves into the shifter. A byte written during a frame is sent as the next frame.
- R8: After the 8th sampled bit, rx_ready is 1 and rx_data holds the byte, with the first bit received in bit 7. An rx_rd pulse clears rx_ready. A read while rx_ready is 0 changes nothing.
- R9: xfer_done is a one-cycle pulse, issued half an SCK period after the last falling edge, while cs_n is still low and sck is 0.
- R10: When a second byte is already queued and hold does not apply, cs_n is high for exactly two module clocks between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpha | input | 1 | Clock phase: 0 drives on falling edges, 1 drives on rising edges |
| cs_hold | input | 1 | Keep select low between frames (only when cpha=1) |
| sck_div | input | DIV_W | Module clocks per SCK period, even, at least 8 |
| tx_data | input | BITS | Byte to send |
| tx_wr | input | 1 | Write pulse into the transmit buffer |
| tx_empty | output | 1 | Transmit buffer can take a byte |
| rx_data | output | BITS | Last received byte |
| rx_rd | input | 1 | Read pulse that clears rx_ready |
| rx_ready | output | 1 | rx_data holds an unread byte |
| xfer_done | output | 1 | End-of-frame pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
A wrong edge count or half-period reload in the clock timer shows on the ports within one frame. The result is a wrong number of SCK rising edges, an uneven toggle spacing, or a byte the slave model receives rotated by a bit. A select-timer state error shows as select rising inside a held burst, a missing or doubled end pulse, or a gap between queued frames that is not two cycles. Each of these is seen within a few cycles of the frame's end. Shifter edge-selection faults turn up as corrupted bytes at both ends on the first frame in the affected phase.

// File: rtl/spi_tmr_pkg.sv
package spi_tmr_pkg;
  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_SETUP,
    SEL_RUN,
    SEL_HOLD,
    SEL_GAP
  } sel_state_e;
endpackage

// File: rtl/spi_tmr_sck_timer.sv
// Clock timer: toggles sck every half period, counts 2*BITS edges.
module spi_tmr_sck_timer #(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             rise,
  output logic             fall,
  output logic             done
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES + 1);

  logic             run_q, run_d;
  logic             sck_q, sck_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [EW-1:0]    edg_q, edg_d;

  always_comb begin
    run_d = run_q;
    sck_d = sck_q;
    cnt_d = cnt_q;
    edg_d = edg_q;
    rise  = 1'b0;
    fall  = 1'b0;
    done  = 1'b0;
    if (start && !run_q) begin
      run_d = 1'b1;
      sck_d = 1'b0;
      cnt_d = half - DIV_W'(1);
      edg_d = '0;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        sck_d = ~sck_q;
        rise  = ~sck_q;
        fall  = sck_q;
        cnt_d = half - DIV_W'(1);
        edg_d = edg_q + EW'(1);
        if (edg_q == EW'(EDGES - 1)) begin
          run_d = 1'b0;
          done  = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sck_q <= 1'b0;
      cnt_q <= '0;
      edg_q <= '0;
    end else begin
      run_q <= run_d;
      sck_q <= sck_d;
      cnt_q <= cnt_d;
      edg_q <= edg_d;
    end
  end

  assign sck = sck_q;
endmodule

// File: rtl/spi_tmr_sel_timer.sv
// Select timer: triggered by the shifter load, frames the clock timer.
module spi_tmr_sel_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_full,
  input  logic             cpha,
  input  logic             hold_en,
  input  logic [DIV_W-1:0] half,
  input  logic             sck_done,
  output logic             load,
  output logic             sck_start,
  output logic             cs_n,
  output logic             done
);
  import spi_tmr_pkg::*;

  sel_state_e       st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cs_q, cs_d;
  logic             keep;

  assign keep = cpha & hold_en;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cs_d      = cs_q;
    load      = 1'b0;
    sck_start = 1'b0;
    done      = 1'b0;
    case (st_q)
      SEL_IDLE: begin
        if (tx_full) begin
          load  = 1'b1;
          cs_d  = 1'b1;
          cnt_d = half - DIV_W'(1);
          st_d  = SEL_SETUP;
        end else if (cs_q && !keep) begin
          cs_d = 1'b0;
          st_d = SEL_GAP;
        end
      end
      SEL_SETUP: begin
        if (cnt_q == '0) begin
          sck_start = 1'b1;
          st_d      = SEL_RUN;
        end else begin
          cnt_d = cnt_q - DIV_W'(1);
        end
      end
      SEL_RUN: begin
        if (sck_done) begin
          cnt_d = half - DIV_W'(1);
          st_d  = SEL_HOLD;
        end
      end
      SEL_HOLD: begin
        if (cnt_q == '0) begin
          done = 1'b1;
          if (keep) begin
            st_d = SEL_IDLE;
          end else begin
            cs_d = 1'b0;
            st_d = SEL_GAP;
          end
        end else begin
          cnt_d = cnt_q - DIV_W'(1);
        end
      end
      SEL_GAP:  st_d = SEL_IDLE;
      default:  st_d = SEL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEL_IDLE;
      cnt_q <= '0;
      cs_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cs_q  <= cs_d;
    end
  end

  assign cs_n = ~cs_q;
endmodule

// File: rtl/spi_tmr_tx_shift.sv
// Transmit shifter: early phase drives on falling, late phase on rising.
module spi_tmr_tx_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpha,
  input  logic            load,
  input  logic [BITS-1:0] data,
  input  logic            rise,
  input  logic            fall,
  output logic            mosi
);
  logic [BITS-1:0] sh_q, sh_d;
  logic            out_q, out_d;
  logic            shift_ev;

  assign shift_ev = cpha ? rise : fall;

  always_comb begin
    sh_d  = sh_q;
    out_d = out_q;
    if (load) begin
      if (cpha) begin
        sh_d  = data;
        out_d = 1'b0;
      end else begin
        sh_d  = {data[BITS-2:0], 1'b0};
        out_d = data[BITS-1];
      end
    end else if (shift_ev) begin
      sh_d  = {sh_q[BITS-2:0], 1'b0};
      out_d = sh_q[BITS-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
    end
  end

  assign mosi = out_q;
endmodule

// File: rtl/spi_tmr_rx_shift.sv
// Receive shifter: samples on the edge opposite to the transmit edge.
module spi_tmr_rx_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpha,
  input  logic            load,
  input  logic            din,
  input  logic            rise,
  input  logic            fall,
  output logic [BITS-1:0] word,
  output logic            got
);
  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sh_q, sh_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            samp;

  assign samp = cpha ? fall : rise;
  assign word = {sh_q[BITS-2:0], din};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    got   = 1'b0;
    if (load) begin
      cnt_d = '0;
    end else if (samp) begin
      sh_d = word;
      if (cnt_q == CW'(BITS - 1)) begin
        got   = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_tmr_master.sv
module spi_tmr_master #(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpha,
  input  logic             cs_hold,
  input  logic [DIV_W-1:0] sck_div,
  input  logic [BITS-1:0]  tx_data,
  input  logic             tx_wr,
  output logic             tx_empty,
  output logic [BITS-1:0]  rx_data,
  input  logic             rx_rd,
  output logic             rx_ready,
  output logic             xfer_done,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int SYNC = 2;

  logic [DIV_W-1:0] half;
  logic             load, sck_start, sck_done, rise, fall, got;
  logic [BITS-1:0]  rx_word;

  logic [BITS-1:0]  txb_q, txb_d;
  logic             full_q, full_d;
  logic [BITS-1:0]  rxb_q, rxb_d;
  logic             rdy_q, rdy_d;
  logic [SYNC-1:0]  sync_q, sync_d;

  assign half = {1'b0, sck_div[DIV_W-1:1]};

  // buffers and input synchronizer, next state
  always_comb begin
    txb_d  = txb_q;
    full_d = full_q;
    if (tx_wr) begin
      txb_d  = tx_data;
      full_d = 1'b1;
    end else if (load) begin
      full_d = 1'b0;
    end
    rxb_d = rxb_q;
    rdy_d = rdy_q;
    if (got) begin
      rxb_d = rx_word;
      rdy_d = 1'b1;
    end else if (rx_rd) begin
      rdy_d = 1'b0;
    end
    sync_d = {sync_q[SYNC-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q  <= '0;
      full_q <= 1'b0;
      rxb_q  <= '0;
      rdy_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      txb_q  <= txb_d;
      full_q <= full_d;
      rxb_q  <= rxb_d;
      rdy_q  <= rdy_d;
      sync_q <= sync_d;
    end
  end

  spi_tmr_sel_timer #(.DIV_W(DIV_W)) sel_i (
    .clk(clk), .rst_n(rst_n), .tx_full(full_q), .cpha(cpha),
    .hold_en(cs_hold), .half(half), .sck_done(sck_done), .load(load),
    .sck_start(sck_start), .cs_n(cs_n), .done(xfer_done)
  );

  spi_tmr_sck_timer #(.BITS(BITS), .DIV_W(DIV_W)) clk_i (
    .clk(clk), .rst_n(rst_n), .start(sck_start), .half(half),
    .sck(sck), .rise(rise), .fall(fall), .done(sck_done)
  );

  spi_tmr_tx_shift #(.BITS(BITS)) txs_i (
    .clk(clk), .rst_n(rst_n), .cpha(cpha), .load(load), .data(txb_q),
    .rise(rise), .fall(fall), .mosi(mosi)
  );

  spi_tmr_rx_shift #(.BITS(BITS)) rxs_i (
    .clk(clk), .rst_n(rst_n), .cpha(cpha), .load(load),
    .din(sync_q[SYNC-1]), .rise(rise), .fall(fall), .word(rx_word), .got(got)
  );

  assign tx_empty = ~full_q;
  assign rx_data  = rxb_q;
  assign rx_ready = rdy_q;
endmodule

// File: rtl/spi_tmr_master_chk.sv
module spi_tmr_master_chk #(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpha,
  input logic [DIV_W-1:0] sck_div,
  input logic             tx_wr,
  input logic             tx_empty,
  input logic             xfer_done,
  input logic             sck,
  input logic             mosi,
  input logic             cs_n,
  input logic [BITS-1:0]  rx_data
);
  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (sck_div >= DIV_W'(8))); // R2
  AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R5
  AST_MOSI_STILL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpha && $stable(cpha) && $rose(sck)) |-> $stable(mosi)); // R3
  AST_MOSI_STILL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpha && $stable(cpha) && $fell(sck)) |-> $stable(mosi)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R9
  AST_DONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!cs_n && !sck)); // R9
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty); // R7
  AST_RX_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> $stable(rx_data)); // R8
endmodule

bind spi_tmr_master spi_tmr_master_chk #(.BITS(BITS), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpha(cpha), .sck_div(sck_div), .tx_wr(tx_wr),
  .tx_empty(tx_empty), .xfer_done(xfer_done), .sck(sck), .mosi(mosi),
  .cs_n(cs_n), .rx_data(rx_data)
);

// File: tb/spi_tmr_master_tb_top.sv
`timescale 1ns/1ps
module spi_tmr_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpha = 1'b0;
  logic       cs_hold = 1'b0;
  logic [7:0] sck_div = 8'd8;
  logic [7:0] tx_data = 8'h00;
  logic       tx_wr = 1'b0;
  logic       rx_rd = 1'b0;
  logic       miso = 1'b0;
  logic       tx_empty, rx_ready, xfer_done, sck, mosi, cs_n;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_tmr_master dut_i (
    .clk(clk), .rst_n(rst_n), .cpha(cpha), .cs_hold(cs_hold), .sck_div(sck_div),
    .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty), .rx_data(rx_data),
    .rx_rd(rx_rd), .rx_ready(rx_ready), .xfer_done(xfer_done), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // slave model, mode follows cpha
  logic [7:0] s_resp = 8'h00;
  logic [7:0] s_out = 8'h00;
  logic [7:0] s_in = 8'h00;
  int         s_cnt = 0;
  logic       sck_prev = 1'b0;
  logic       cs_prev = 1'b1;
  always @(sck or cs_n) begin
    if (cs_prev && !cs_n) begin
      s_out = s_resp;
      s_cnt = 0;
      if (!cpha) miso = s_resp[7];
    end else if (!cs_n && !sck_prev && sck) begin
      if (!cpha) s_in = {s_in[6:0], mosi};
      else begin
        miso  = s_out[7];
        s_out = {s_out[6:0], 1'b0};
      end
    end else if (!cs_n && sck_prev && !sck) begin
      if (!cpha) begin
        s_out = {s_out[6:0], 1'b0};
        miso  = s_out[7];
      end else begin
        s_in  = {s_in[6:0], mosi};
        s_cnt = s_cnt + 1;
        if (s_cnt == 8) begin
          s_cnt = 0;
          s_out = s_resp;
        end
      end
    end
    sck_prev = sck;
    cs_prev  = cs_n;
  end

  // port monitor: toggle spacing, rising edges, select rises
  int   gap_min = 0, gap_max = 0, run = 0, rises = 0, cs_rises = 0;
  logic seen = 1'b0, sck_l = 1'b0, cs_l = 1'b1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cs_l && !cs_n) begin
      seen = 1'b0; rises = 0; gap_min = 9999; gap_max = 0;
    end
    if (!cs_l && cs_n) cs_rises = cs_rises + 1;
    if (sck != sck_l) begin
      if (seen) begin
        if (run < gap_min) gap_min = run;
        if (run > gap_max) gap_max = run;
      end
      if (sck) rises = rises + 1;
      seen = 1'b1;
      run = 1;
    end else begin
      run = run + 1;
    end
    sck_l = sck;
    cs_l  = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (xfer_done) return;
    end
    chk(1'b0, "R9 end pulse timeout", 0, 1);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk(rx_ready == 1'b0, "R8 read clears ready", int'(rx_ready), 0);
  endtask

  // {cpha, divider, tx byte, slave response}
  localparam logic [24:0] VEC [0:5] = '{
    {1'b0, 8'd8,  8'hA5, 8'h3C},
    {1'b0, 8'd12, 8'h01, 8'h80},
    {1'b1, 8'd8,  8'hFF, 8'h00},
    {1'b1, 8'd10, 8'h5A, 8'hC3},
    {1'b0, 8'd16, 8'h80, 8'h7E},
    {1'b1, 8'd20, 8'h00, 8'hFF}
  };

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({cs_n, sck, mosi, tx_empty, rx_ready, xfer_done} == 6'b100100,
        "R1 reset outputs", int'({cs_n, sck, mosi, tx_empty, rx_ready, xfer_done}), 'h24);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk
    for (int v = 0; v < 6; v++) begin
      cpha    = VEC[v][24];
      sck_div = VEC[v][23:16];
      s_resp  = VEC[v][7:0];
      write_byte(VEC[v][15:8]);
      chk(tx_empty == 1'b0, "R7 write fills buffer", int'(tx_empty), 0);
      @(negedge clk);
      chk(tx_empty == 1'b1 && cs_n == 1'b0, "R5 R7 load and select",
          int'({tx_empty, cs_n}), 'h2);
      wait_done();
      chk(cs_n == 1'b0 && sck == 1'b0, "R9 end pulse while selected", int'({cs_n, sck}), 0);
      chk(rises == 8, "R2 eight rising edges", rises, 8);
      chk(gap_min == int'(sck_div) / 2 && gap_max == int'(sck_div) / 2,
          "R2 half period", gap_max, int'(sck_div) / 2);
      chk(s_in == VEC[v][15:8], VEC[v][24] ? "R4 slave got byte" : "R3 slave got byte",
          int'(s_in), int'(VEC[v][15:8]));
      chk(rx_ready == 1'b1 && rx_data == VEC[v][7:0], "R8 received byte",
          int'(rx_data), int'(VEC[v][7:0]));
      @(negedge clk);
      chk(xfer_done == 1'b0 && cs_n == 1'b1, "R9 R5 pulse ends, select released",
          int'({xfer_done, cs_n}), 1);
      read_rx();
      repeat (3) @(negedge clk);
    end

    // R8 read with nothing ready
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
    chk(rx_ready == 1'b0 && rx_data == 8'hFF, "R8 idle read no effect", int'(rx_data), 'hFF);

    // R6 held select, late phase
    cpha = 1'b1; cs_hold = 1'b1; sck_div = 8'd8; s_resp = 8'h96;
    begin
      int r0;
      r0 = cs_rises;
      write_byte(8'hC5);
      wait_done();
      @(negedge clk);
      read_rx();
      write_byte(8'h3A);
      wait_done();
      repeat (3) @(negedge clk);
      chk(cs_rises == r0 && cs_n == 1'b0, "R6 select held across frames",
          cs_rises - r0, 0);
      chk(s_in == 8'h3A && rx_data == 8'h96, "R6 R4 held frame data",
          int'(s_in), 'h3A);
      cs_hold = 1'b0;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R6 release after hold drops", int'(cs_n), 1);
      read_rx();
    end

    // R6 hold ignored in early phase
    cpha = 1'b0; cs_hold = 1'b1; s_resp = 8'h69;
    repeat (2) @(negedge clk);
    write_byte(8'h17);
    wait_done();
    @(negedge clk);
    chk(cs_n == 1'b1, "R6 hold ignored with cpha=0", int'(cs_n), 1);
    chk(rx_data == 8'h69 && s_in == 8'h17, "R3 data with hold set", int'(rx_data), 'h69);
    read_rx();
    cs_hold = 1'b0;
    repeat (3) @(negedge clk);

    // R7 R10 byte queued during a frame
    s_resp = 8'h4B;
    write_byte(8'hE1);
    repeat (6) @(negedge clk);
    write_byte(8'h2D);
    chk(tx_empty == 1'b0 && cs_n == 1'b0, "R7 queued during frame", int'(tx_empty), 0);
    wait_done();
    chk(s_in == 8'hE1, "R7 first queued byte", int'(s_in), 'hE1);
    begin
      int hi;
      hi = 0;
      @(negedge clk);
      while (cs_n && hi < 50) begin
        hi = hi + 1;
        @(negedge clk);
      end
      chk(hi == 2, "R10 gap between queued frames", hi, 2);
    end
    chk(tx_empty == 1'b1, "R7 queued byte taken", int'(tx_empty), 1);
    wait_done();
    chk(s_in == 8'h2D && rx_data == 8'h4B, "R7 second frame data", int'(s_in), 'h2D);
    @(negedge clk);
    read_rx();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule